// File: doc/BRIEF.md
# Command Response Capture FIFO

This block sits behind the command line of an SD/MMC host. After a command is issued it watches the line one sample at a time. It finds the start bit of the card's reply and assembles the reply into 16-bit halfwords. A bus master then pops these halfwords one at a time from a single read port.

The response-format code given with the command start selects the shape of the reply:
- A short 48-bit reply yields three halfwords. Software rebuilds the 32-bit payload as `h0<<24 | h1<<8 | (h2 & 0xFF)`.
- A long 136-bit reply yields nine halfwords. Payload word i is built from the low byte of halfword 2i shifted left by 24, all of halfword 2i+1 shifted left by 8, and the high byte of halfword 2i+2.

When the whole frame has been sampled, a one-cycle done pulse is raised together with the frame length in bits.

The capture engine is a four-state machine:
- **IDLE**: nothing is pending.
- **HUNT**: the engine waits for a sampled 0 on the line. This is the start bit.
- **RECV**: the engine shifts in frame bits until the last one arrives.
- **FIN**: a one-cycle state that raises the done pulse.

Its transitions are:
- **start/hunt**: a command start with a short or long code moves any state to HUNT.
- **start/none**: a command start with a no-response code moves any state straight to FIN.
- **found**: a sampled 0 moves HUNT to RECV.
- **last**: the final frame bit moves RECV to FIN.
- **retire**: FIN always returns to IDLE.

Top module: `rsp_capture_fifo`

## Requirements
- R1: After reset the done output is low, the done length is 0 and a read returns 0.
- R2: Format code 2 selects the long 136-bit reply, and codes 1 and 3 select the short 48-bit reply. Codes 0 and 4 to 7 expect no reply: done pulses on the cycle after the start with length 0, no line samples are stored, and later reads return 0.
- R3: While hunting, samples of 1 on the line are ignored. The first sampled 0 is the start bit and is frame bit 0.
- R4: For a short reply, h0 holds frame bits 0..15 and h1 holds frame bits 16..31, MSB first. h2 holds frame bits 32..39 in its low byte with its high byte 0. The CRC and end bits are not stored. `h0[7:0], h1, h2[7:0]` equals the 32-bit payload.
- R5: For a long reply, halfword k holds frame bits 16k..16k+15, MSB first. The ninth halfword holds frame bits 128..135 in its high byte and zeros in its low byte.
- R6: Each read pulse pops one halfword in arrival order, and the read data appears on the cycle after the pulse. Without a read pulse the read data holds its value.
- R7: A read of an empty FIFO returns 0 and does not move the read position.
- R8: A command start discards all unread halfwords and aborts any capture in progress.
- R9: Done is a one-cycle pulse on the cycle after the last frame bit is sampled. Its length output reads 48 for a short reply and 136 for a long reply, and 0 when done is low.
- R10: The line is only sampled in cycles where the sample strobe is high. Line values in other cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse: a command has been issued |
| fmt_i | input | 3 | Response-format code, taken with start_i |
| bit_en_i | input | 1 | Sample strobe for the command line |
| cmd_i | input | 1 | Command line level |
| rd_i | input | 1 | Read pulse that pops one halfword |
| rd_data_o | output | 16 | Popped halfword, valid on the cycle after rd_i |
| done_o | output | 1 | End-of-response pulse |
| done_bits_o | output | 8 | Frame length in bits, shown with done_o |

## Verification
The assertions check several rules on every cycle:
- the done pulse lasts one cycle;
- the length value is one of 0, 48 or 136, and is 0 outside the pulse;
- a command start empties the FIFO;
- an empty read yields 0;
- the read data holds without a read pulse;
- the FIFO fill never exceeds nine entries.

Only the bench's scenarios can show the rest:
- the bit packing of short and long replies and the payload rebuilt from it;
- that idle-high samples and unstrobed cycles are ignored;
- that a start in mid-capture discards the partial reply;
- the exact cycle of the done pulse.

// File: rtl/rspcap_pkg.sv
package rspcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_RECV,
        ST_FIN
    } cap_state_e;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_SHORT,
        KIND_LONG
    } rsp_kind_e;

    // Format code -> reply shape; 2 is the long reply, 1 and 3 are short.
    function automatic rsp_kind_e fmt_to_kind(input logic [2:0] fmt);
        case (fmt)
            3'd1, 3'd3: return KIND_SHORT;
            3'd2:       return KIND_LONG;
            default:    return KIND_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rspcap_deser.sv
module rspcap_deser
    import rspcap_pkg::*;
#(
    parameter int HW         = 16,
    parameter int SHORT_BITS = 48,
    parameter int SHORT_KEEP = 40,
    parameter int LONG_BITS  = 136,
    localparam int CW        = $clog2(LONG_BITS),
    localparam int LW        = $clog2(LONG_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [2:0]    fmt_i,
    input  logic          bit_en_i,
    input  logic          cmd_i,
    output logic          wr_o,
    output logic [HW-1:0] wr_data_o,
    output logic          done_o,
    output logic [LW-1:0] done_bits_o
);

    localparam int HWB      = $clog2(HW);
    localparam int LONG_REM = LONG_BITS % HW;
    localparam int PAD      = (HW - LONG_REM) % HW;

    cap_state_e        state_q, state_d;
    rsp_kind_e         kind_q;
    logic [CW-1:0]     cnt_q;
    logic [HW-2:0]     acc_q;
    logic [HW-1:0]     nxt_acc;
    logic [CW-1:0]     last_idx;
    logic              at_last, boundary, take, found;

    assign nxt_acc  = {acc_q, cmd_i};
    assign last_idx = (kind_q == KIND_LONG) ? CW'(LONG_BITS - 1) : CW'(SHORT_BITS - 1);
    assign at_last  = (cnt_q == last_idx);
    assign boundary = (cnt_q[HWB-1:0] == '1);
    assign take     = (state_q == ST_RECV) && bit_en_i && !start_i;
    assign found    = (state_q == ST_HUNT) && bit_en_i && !cmd_i && !start_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = (fmt_to_kind(fmt_i) == KIND_NONE) ? ST_FIN : ST_HUNT;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_HUNT: if (found) state_d = ST_RECV;
                ST_RECV: if (bit_en_i && at_last) state_d = ST_FIN;
                ST_FIN:  state_d = ST_IDLE;
            endcase
        end
    end

    // Halfword write decision
    always_comb begin
        wr_o      = 1'b0;
        wr_data_o = nxt_acc;
        if (take) begin
            if (kind_q == KIND_LONG) begin
                wr_o = boundary || at_last;
                if (at_last) wr_data_o = nxt_acc << PAD;
            end else if (cnt_q < CW'(SHORT_KEEP)) begin
                wr_o = boundary || (cnt_q == CW'(SHORT_KEEP - 1));
            end
        end
    end

    // Bit counter and assembler
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= KIND_NONE;
            cnt_q  <= '0;
            acc_q  <= '0;
        end else if (start_i) begin
            kind_q <= fmt_to_kind(fmt_i);
            cnt_q  <= '0;
            acc_q  <= '0;
        end else if (found) begin
            cnt_q  <= CW'(1);
            acc_q  <= '0;
        end else if (take) begin
            cnt_q  <= cnt_q + CW'(1);
            acc_q  <= wr_o ? '0 : nxt_acc[HW-2:0];
        end
    end

    // Outputs
    always_comb begin
        done_o      = (state_q == ST_FIN);
        done_bits_o = '0;
        if (done_o) begin
            unique case (kind_q)
                KIND_LONG:  done_bits_o = LW'(LONG_BITS);
                KIND_SHORT: done_bits_o = LW'(SHORT_BITS);
                default:    done_bits_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/rspcap_store.sv
module rspcap_store #(
    parameter int HW    = 16,
    parameter int DEPTH = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          wr_i,
    input  logic [HW-1:0] wr_data_i,
    input  logic          rd_i,
    output logic [HW-1:0] rd_data_o,
    output logic          empty_o,
    output logic [PW-1:0] fill_o
);

    logic [HW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr_q, rptr_q;

    assign empty_o = (rptr_q == wptr_q);
    assign fill_o  = wptr_q;

    always_ff @(posedge clk) begin
        if (wr_i && !clear_i && (wptr_q < PW'(DEPTH)))
            mem[wptr_q[AW-1:0]] <= wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q    <= '0;
            rptr_q    <= '0;
            rd_data_o <= '0;
        end else begin
            if (rd_i)
                rd_data_o <= empty_o ? '0 : mem[rptr_q[AW-1:0]];
            if (clear_i) begin
                wptr_q <= '0;
                rptr_q <= '0;
            end else begin
                if (wr_i && (wptr_q < PW'(DEPTH))) wptr_q <= wptr_q + PW'(1);
                if (rd_i && !empty_o)              rptr_q <= rptr_q + PW'(1);
            end
        end
    end

endmodule

// File: rtl/rsp_capture_fifo.sv
module rsp_capture_fifo #(
    parameter int HW         = 16,
    parameter int SHORT_BITS = 48,
    parameter int SHORT_KEEP = 40,
    parameter int LONG_BITS  = 136
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start_i,
    input  logic [2:0]                         fmt_i,
    input  logic                               bit_en_i,
    input  logic                               cmd_i,
    input  logic                               rd_i,
    output logic [HW-1:0]                      rd_data_o,
    output logic                               done_o,
    output logic [$clog2(LONG_BITS + 1)-1:0]   done_bits_o
);

    localparam int DEPTH = (LONG_BITS + HW - 1) / HW;
    localparam int PW    = $clog2(DEPTH + 1);

    logic          wr_en;
    logic [HW-1:0] wr_word;
    logic          fifo_empty;
    logic [PW-1:0] fill_cnt;

    rspcap_deser #(
        .HW(HW), .SHORT_BITS(SHORT_BITS), .SHORT_KEEP(SHORT_KEEP), .LONG_BITS(LONG_BITS)
    ) u_deser (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fmt_i(fmt_i),
        .bit_en_i(bit_en_i), .cmd_i(cmd_i), .wr_o(wr_en), .wr_data_o(wr_word),
        .done_o(done_o), .done_bits_o(done_bits_o)
    );

    rspcap_store #(.HW(HW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clear_i(start_i), .wr_i(wr_en),
        .wr_data_i(wr_word), .rd_i(rd_i), .rd_data_o(rd_data_o),
        .empty_o(fifo_empty), .fill_o(fill_cnt)
    );

endmodule

// File: rtl/rspcap_chk.sv
module rspcap_chk #(
    parameter int HW         = 16,
    parameter int SHORT_BITS = 48,
    parameter int LONG_BITS  = 136,
    parameter int DEPTH      = 9,
    localparam int LW        = $clog2(LONG_BITS + 1),
    localparam int PW        = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          rd_i,
    input logic [HW-1:0] rd_data_o,
    input logic          done_o,
    input logic [LW-1:0] done_bits_o,
    input logic          fifo_empty,
    input logic [PW-1:0] fill_cnt
);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> !done_o);

    // R9
    done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (done_bits_o == '0 || done_bits_o == LW'(SHORT_BITS) || done_bits_o == LW'(LONG_BITS)));

    // R9
    len_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> done_bits_o == '0);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> fifo_empty);

    // R7
    empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i && fifo_empty |=> rd_data_o == '0);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rd_data_o));

    // R5
    fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= PW'(DEPTH));

endmodule

bind rsp_capture_fifo rspcap_chk #(
    .HW(HW), .SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS), .DEPTH(DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
    .rd_data_o(rd_data_o), .done_o(done_o), .done_bits_o(done_bits_o),
    .fifo_empty(fifo_empty), .fill_cnt(fill_cnt)
);

// File: tb/rsp_capture_fifo_tb.sv
module rsp_capture_fifo_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  fmt_i = '0;
    logic        bit_en_i = 1'b0;
    logic        cmd_i = 1'b1;
    logic        rd_i = 1'b0;
    logic [15:0] rd_data_o;
    logic        done_o;
    logic [7:0]  done_bits_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rsp_capture_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fmt_i(fmt_i),
        .bit_en_i(bit_en_i), .cmd_i(cmd_i), .rd_i(rd_i),
        .rd_data_o(rd_data_o), .done_o(done_o), .done_bits_o(done_bits_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic start_cmd(input logic [2:0] f);
        @(negedge clk); start_i = 1'b1; fmt_i = f;
        @(negedge clk); start_i = 1'b0;
    endtask

    // Sends n bits MSB first; gap idle cycles between bits carry the inverted level.
    task automatic send_bits(input logic [143:0] v, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_en_i = 1'b1; cmd_i = v[n-1-i];
            if (gap > 0 && i != n - 1) begin
                @(negedge clk); bit_en_i = 1'b0; cmd_i = ~v[n-1-i];
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk); bit_en_i = 1'b0; cmd_i = 1'b1;
    endtask

    task automatic pop(output logic [15:0] d);
        @(negedge clk); rd_i = 1'b1;
        @(negedge clk); rd_i = 1'b0;
        d = rd_data_o;
    endtask

    function automatic logic [47:0] short_frame(input logic [31:0] pl);
        return {2'b00, 6'h2a, pl, 7'h35, 1'b1};
    endfunction

    task automatic t_reset();
        logic [15:0] d;
        check("R1 done after reset", {31'd0, done_o}, 32'd0);
        check("R1 length after reset", {24'd0, done_bits_o}, 32'd0);
        check("R1 read data after reset", {16'd0, rd_data_o}, 32'd0);
        pop(d);
        check("R7 empty read after reset", {16'd0, d}, 32'd0);
    endtask

    task automatic t_short(input logic [2:0] f, input logic [31:0] pl, input int gap);
        logic [47:0] sf;
        logic [15:0] h0, h1, h2, h3;
        sf = short_frame(pl);
        start_cmd(f);
        send_bits(144'h7, 3, 0);                       // R3 idle-high samples
        send_bits({96'd0, sf}, 48, gap);
        check("R9 short done pulse", {31'd0, done_o}, 32'd1);
        check("R9 short length", {24'd0, done_bits_o}, 32'd48);
        @(negedge clk);
        check("R9 done lasts one cycle", {31'd0, done_o}, 32'd0);
        pop(h0); pop(h1); pop(h2);
        check("R4 h0", {16'd0, h0}, {16'd0, sf[47:32]});
        check("R4 h1", {16'd0, h1}, {16'd0, sf[31:16]});
        check("R4 h2", {16'd0, h2}, {24'd0, sf[15:8]});
        check("R4 payload rebuild", {h0[7:0], h1, h2[7:0]}, pl);
        if (gap > 0) check("R10 strobed bits only", {h0[7:0], h1, h2[7:0]}, pl);
        pop(h3);
        check("R7 read past end", {16'd0, h3}, 32'd0);
        pop(h3);
        check("R7 second read past end", {16'd0, h3}, 32'd0);
    endtask

    task automatic t_long(input logic [126:0] body);
        logic [135:0] lf;
        logic [143:0] pad;
        logic [15:0]  h [9];
        logic [31:0]  w;
        lf  = {2'b00, 6'h3f, body, 1'b1};
        pad = {lf, 8'h00};
        start_cmd(3'd2);
        send_bits(144'h3, 2, 0);                       // R3
        send_bits({8'd0, lf}, 136, 0);
        check("R9 long done pulse", {31'd0, done_o}, 32'd1);
        check("R9 long length", {24'd0, done_bits_o}, 32'd136);
        for (int k = 0; k < 9; k++) begin
            pop(h[k]);
            check($sformatf("R5 halfword %0d", k), {16'd0, h[k]}, {16'd0, pad[143-16*k -: 16]});
        end
        check("R5 last low byte zero", {24'd0, h[8][7:0]}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            w = ({24'd0, h[2*i][7:0]} << 24) | ({16'd0, h[2*i+1]} << 8) | ({16'd0, h[2*i+2]} >> 8);
            check($sformatf("R5 word %0d rebuild", i), w, lf[127-32*i -: 32]);
        end
    endtask

    task automatic t_none(input logic [2:0] f);
        logic [15:0] d;
        start_cmd(f);
        check("R2 no-reply done", {31'd0, done_o}, 32'd1);
        check("R2 no-reply length", {24'd0, done_bits_o}, 32'd0);
        send_bits({96'd0, short_frame(32'h1234_5678)}, 48, 0);
        check("R2 no capture without reply", {31'd0, done_o}, 32'd0);
        pop(d);
        check("R2 nothing stored", {16'd0, d}, 32'd0);
    endtask

    task automatic t_clear();
        logic [47:0]  sf;
        logic [15:0]  d;
        start_cmd(3'd1);
        send_bits({96'd0, short_frame(32'hdead_beef)}, 48, 0);
        pop(d);
        start_cmd(3'd1);
        pop(d);
        check("R8 start discards unread", {16'd0, d}, 32'd0);
        start_cmd(3'd2);
        send_bits({96'd0, short_frame(32'hffff_0000)}, 20, 0);
        sf = short_frame(32'h0bad_cafe);
        start_cmd(3'd3);
        send_bits({96'd0, sf}, 48, 0);
        check("R8 restart length", {24'd0, done_bits_o}, 32'd48);
        pop(d);
        check("R8 restart h0", {16'd0, d}, {16'd0, sf[47:32]});
        pop(d);
        check("R6 order h1", {16'd0, d}, {16'd0, sf[31:16]});
        repeat (3) @(negedge clk);
        check("R6 data holds without read", {16'd0, rd_data_o}, {16'd0, sf[31:16]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short(3'd1, 32'hc3a5_5a3c, 0);
        t_short(3'd3, 32'h8001_7ffe, 2);
        t_long({127{2'b10}} >> 0);
        t_long({32'h0123_4567, 32'h89ab_cdef, 32'hfedc_ba98, 31'h7654_3210});
        t_none(3'd0);
        t_none(3'd5);
        t_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule